// File: doc/BRIEF.md
# Indirect Byte-Register Access Bridge

This block lets a host with a 32-bit memory-mapped port reach a slow register space that is addressed by 8 bits and moves one byte per access. Real-time-clock calendars, timers and alarm controls are typical of such spaces. The host does not reach the inner registers directly. It programs a command word that holds an inner address, a direction bit and byte-lane enables. It then polls a busy bit until the inner transfer is done. Data moves through a lower data word. An upper data word is also available to the host as storage.

A read starts as soon as a command word with the direction bit set is written. When busy drops, the returned byte is in the low byte of the lower data word. A write takes two steps. First the host writes a command word with the direction bit clear, which arms the bridge. Then the host writes the lower data word, which launches the transfer. The inner side is a request/acknowledge handshake in the same clock domain. The bridge also keeps a 2-bit interrupt enable register and a 2-bit interrupt flag register. The flags record a level request from the subsystem and each completed transfer.

The transfer controller has four states:
- `ST_IDLE`: nothing is armed.
- `ST_ARMED`: a write command is waiting for its data.
- `ST_RD`: an inner read is requested.
- `ST_WR`: an inner write is requested.

Its transitions are:
- IDLE→RD and ARMED→RD: a command write with direction 1.
- IDLE→ARMED: a command write with direction 0.
- ARMED→ARMED: another direction-0 command write re-arms the bridge.
- ARMED→WR: a lower-data write.
- RD→IDLE and WR→IDLE: the inner acknowledge.

Top module: `slowreg_bridge`

## Requirements
- R1: After reset, the following all read as 0: busy, `in_req`, `irq_o`, the command word, both data words, the enable register and the flag register.
- R2: Offset 0x00 always reads the parameter `ID_VALUE`. Writes to 0x00 have no effect.
- R3: The command word at 0x04 reads back as follows. Bit 31 is busy. Bit 24 is the direction. Bits 23:16 are the byte enables, with the upper-data enables in 23:20 and the lower-data enables in 19:16. Bits 7:0 are the inner address. Every other bit reads 0.
- R4: A command write with bit 24 = 1 raises `in_req` on the next cycle, with `in_we`=0 and `in_addr` set to the commanded address. Busy reads 1 until the acknowledge.
- R5: On the clock edge where `in_ack` is high, busy clears. The lower data word at 0x08 then holds `in_rdata` in bits 7:0, and bits 31:8 read 0.
- R6: A command write with bit 24 = 0 issues no inner request. A following write to 0x08 raises `in_req` with `in_we`=1 and `in_wdata` equal to that value's bits 7:0.
- R7: While `in_req` is high and `in_ack` is low, `in_req`, `in_we`, `in_addr` and `in_wdata` hold their values. `in_req` is low the cycle after an acknowledge.
- R8: While busy is set, host writes to the command word and to the lower data word are ignored.
- R9: The flag register is at 0x14. Bit 1 sets in every cycle that `sub_irq` is high. Bit 0 sets on every completed inner transfer. Writing 1 to a bit clears it, unless a set happens in the same cycle, in which case the set wins.
- R10: `irq_o` is high exactly when some flag bit is set and the same bit of the enable register at 0x10 is set. Bit 1 is the subsystem request and bit 0 is the transfer interface.
- R11: The upper data word at 0x0C stores and returns any 32-bit value. It never starts a transfer.
- R12: A write to 0x08 with no armed command stores the value and issues no inner request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hst_sel | input | 1 | Host access select |
| hst_wr | input | 1 | Host write strobe (with hst_sel) |
| hst_addr | input | 5 | Host byte address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, combinational from hst_addr |
| in_req | output | 1 | Inner transfer request |
| in_we | output | 1 | Inner direction, 1 = write |
| in_addr | output | 8 | Inner register address |
| in_wdata | output | 8 | Inner write byte |
| in_ack | input | 1 | Inner acknowledge, ends the transfer |
| in_rdata | input | 8 | Inner read byte, valid with in_ack |
| sub_irq | input | 1 | Level interrupt request from the subsystem |
| irq_o | output | 1 | Host interrupt |

## Verification
A wrong controller state shows up at the ports on the very next cycle. If `in_req` rises after a bare write command, or stays low after a data write, the fault is visible one clock after the host access. A stuck busy bit shows up at the next poll of the command word. If the captured byte goes to the wrong place, the lower data word reads wrong right after the acknowledge. Flag faults appear as a wrong `irq_o` on the cycle after the set or clear, because the output is a plain AND-OR of the stored bits.

// File: rtl/slowreg_pkg.sv
package slowreg_pkg;
    localparam int HOST_AW  = 5;
    localparam int HOST_DW  = 32;
    localparam int INNER_AW = 8;
    localparam int INNER_DW = 8;
    localparam int IRQ_N    = 2;

    localparam logic [HOST_AW-1:0] OFS_ID   = 5'h00;
    localparam logic [HOST_AW-1:0] OFS_CMD  = 5'h04;
    localparam logic [HOST_AW-1:0] OFS_LDAT = 5'h08;
    localparam logic [HOST_AW-1:0] OFS_UDAT = 5'h0C;
    localparam logic [HOST_AW-1:0] OFS_IEN  = 5'h10;
    localparam logic [HOST_AW-1:0] OFS_IFLG = 5'h14;

    localparam int CMD_BUSY_BIT = 31;
    localparam int CMD_DIR_BIT  = 24;
    localparam int CMD_BEN_LO   = 16;
    localparam int CMD_BEN_W    = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RD    = 2'd2,
        ST_WR    = 2'd3
    } xfer_state_e;
endpackage

// File: rtl/slowreg_xfer_fsm.sv
module slowreg_xfer_fsm
    import slowreg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic cmd_dir,
    input  logic ldata_wr,
    input  logic in_ack,
    output logic busy,
    output logic in_req,
    output logic in_we,
    output logic done,
    output logic rd_done
);
    xfer_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_ARMED: begin
                if (cmd_wr)
                    state_d = cmd_dir ? ST_RD : ST_ARMED;
                else if (ldata_wr && state_q == ST_ARMED)
                    state_d = ST_WR;
            end
            ST_RD, ST_WR: begin
                if (in_ack) state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        in_req  = 1'b0;
        in_we   = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_ARMED: ;
            ST_RD: in_req = 1'b1;
            ST_WR: begin
                in_req = 1'b1;
                in_we  = 1'b1;
            end
        endcase
        busy    = in_req;
        done    = in_req & in_ack;
        rd_done = (state_q == ST_RD) & in_ack;
    end

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_req && !in_ack |=> in_req && (in_we == $past(in_we)));
    // R7
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_req && in_ack |=> !in_req);
    // R6
    armed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_req && cmd_wr && !cmd_dir |=> !in_req);
endmodule

// File: rtl/slowreg_irq.sv
module slowreg_irq #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic         en_wr,
    input  logic         clr_wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] en_q,
    output logic [N-1:0] flg_q,
    output logic         irq
);
    logic [N-1:0] clr_mask;

    always_comb clr_mask = clr_wr ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            flg_q <= '0;
        end else begin
            if (en_wr) en_q <= wdata;
            flg_q <= (flg_q & ~clr_mask) | set_vec;
        end
    end

    always_comb irq = |(flg_q & en_q);

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr && wdata[0] && !set_vec[0] |=> !flg_q[0]);
    // R9
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[N-1] |=> flg_q[N-1]);
endmodule

// File: rtl/slowreg_bridge.sv
module slowreg_bridge
    import slowreg_pkg::*;
#(
    parameter logic [HOST_DW-1:0] ID_VALUE = 32'h5A1E_0100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hst_sel,
    input  logic                hst_wr,
    input  logic [HOST_AW-1:0]  hst_addr,
    input  logic [HOST_DW-1:0]  hst_wdata,
    output logic [HOST_DW-1:0]  hst_rdata,
    output logic                in_req,
    output logic                in_we,
    output logic [INNER_AW-1:0] in_addr,
    output logic [INNER_DW-1:0] in_wdata,
    input  logic                in_ack,
    input  logic [INNER_DW-1:0] in_rdata,
    input  logic                sub_irq,
    output logic                irq_o
);
    localparam int PAD_W = HOST_DW - INNER_DW;

    logic                  wr_any, cmd_hit, ldat_hit;
    logic                  cmd_wr_ok, ldat_wr_ok;
    logic                  busy, done, rd_done;
    logic                  cmd_dir_q;
    logic [CMD_BEN_W-1:0]  cmd_ben_q;
    logic [INNER_AW-1:0]   cmd_addr_q;
    logic [HOST_DW-1:0]    ldata_q, udata_q, cmd_view;
    logic [IRQ_N-1:0]      ien_q, iflg_q;

    always_comb begin
        wr_any     = hst_sel & hst_wr;
        cmd_hit    = wr_any && hst_addr == OFS_CMD;
        ldat_hit   = wr_any && hst_addr == OFS_LDAT;
        cmd_wr_ok  = cmd_hit & ~busy;
        ldat_wr_ok = ldat_hit & ~busy;
    end

    slowreg_xfer_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_wr  (cmd_wr_ok),
        .cmd_dir (hst_wdata[CMD_DIR_BIT]),
        .ldata_wr(ldat_wr_ok),
        .in_ack  (in_ack),
        .busy    (busy),
        .in_req  (in_req),
        .in_we   (in_we),
        .done    (done),
        .rd_done (rd_done)
    );

    slowreg_irq #(.N(IRQ_N)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec({sub_irq, done}),
        .en_wr  (wr_any && hst_addr == OFS_IEN),
        .clr_wr (wr_any && hst_addr == OFS_IFLG),
        .wdata  (hst_wdata[IRQ_N-1:0]),
        .en_q   (ien_q),
        .flg_q  (iflg_q),
        .irq    (irq_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_dir_q  <= 1'b0;
            cmd_ben_q  <= '0;
            cmd_addr_q <= '0;
            ldata_q    <= '0;
            udata_q    <= '0;
        end else begin
            if (cmd_wr_ok) begin
                cmd_dir_q  <= hst_wdata[CMD_DIR_BIT];
                cmd_ben_q  <= hst_wdata[CMD_BEN_LO +: CMD_BEN_W];
                cmd_addr_q <= hst_wdata[INNER_AW-1:0];
            end
            if (rd_done)
                ldata_q <= {{PAD_W{1'b0}}, in_rdata};
            else if (ldat_wr_ok)
                ldata_q <= hst_wdata;
            if (wr_any && hst_addr == OFS_UDAT)
                udata_q <= hst_wdata;
        end
    end

    always_comb begin
        cmd_view = '0;
        cmd_view[CMD_BUSY_BIT]                = busy;
        cmd_view[CMD_DIR_BIT]                 = cmd_dir_q;
        cmd_view[CMD_BEN_LO +: CMD_BEN_W]     = cmd_ben_q;
        cmd_view[INNER_AW-1:0]                = cmd_addr_q;
        in_addr  = cmd_addr_q;
        in_wdata = ldata_q[INNER_DW-1:0];
        unique case (hst_addr)
            OFS_ID:   hst_rdata = ID_VALUE;
            OFS_CMD:  hst_rdata = cmd_view;
            OFS_LDAT: hst_rdata = ldata_q;
            OFS_UDAT: hst_rdata = udata_q;
            OFS_IEN:  hst_rdata = {{(HOST_DW-IRQ_N){1'b0}}, ien_q};
            OFS_IFLG: hst_rdata = {{(HOST_DW-IRQ_N){1'b0}}, iflg_q};
            default:  hst_rdata = '0;
        endcase
    end

    // R8
    busy_cmd_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !in_ack |=> $stable(cmd_addr_q) && $stable(cmd_dir_q));
    // R7
    wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_req && !in_ack |=> $stable(in_addr) && $stable(in_wdata));
    // R5
    rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_req && !in_we && in_ack |=> ldata_q[INNER_DW-1:0] == $past(in_rdata));
endmodule

// File: tb/slowreg_bridge_tb_top.sv
module slowreg_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_sel = 1'b0, hst_wr = 1'b0;
    logic [4:0]  hst_addr = '0;
    logic [31:0] hst_wdata = '0, hst_rdata;
    logic        in_req, in_we;
    logic [7:0]  in_addr, in_wdata;
    logic        in_ack = 1'b0;
    logic [7:0]  in_rdata = '0;
    logic        sub_irq = 1'b0;
    logic        irq_o;

    int n_run = 0, n_fail = 0;
    bit finished = 0;
    localparam logic [31:0] IDV = 32'h5A1E_0100;

    always #4 clk = ~clk;

    slowreg_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .hst_sel(hst_sel), .hst_wr(hst_wr),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .in_req(in_req), .in_we(in_we), .in_addr(in_addr), .in_wdata(in_wdata),
        .in_ack(in_ack), .in_rdata(in_rdata), .sub_irq(sub_irq), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        hst_sel = 1'b1; hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_sel = 1'b0; hst_wr = 1'b0;
    endtask

    task automatic hread(input logic [4:0] a, output logic [31:0] d);
        hst_addr = a;
        #1;
        d = hst_rdata;
    endtask

    task automatic ack_with(input logic [7:0] b);
        @(negedge clk);
        in_ack = 1'b1; in_rdata = b;
        @(negedge clk);
        in_ack = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        hread(5'h04, v); chk("R1 cmd", v, 0);
        hread(5'h08, v); chk("R1 ldata", v, 0);
        hread(5'h0C, v); chk("R1 udata", v, 0);
        hread(5'h10, v); chk("R1 ien", v, 0);
        hread(5'h14, v); chk("R1 iflg", v, 0);
        chk("R1 req/irq", {30'd0, in_req, irq_o}, 0);
    endtask

    task automatic t_id;
        logic [31:0] v;
        hread(5'h00, v); chk("R2 id", v, IDV);
        hwrite(5'h00, 32'h1234_5678);
        hread(5'h00, v); chk("R2 id after write", v, IDV);
    endtask

    task automatic t_read;
        logic [31:0] v;
        hwrite(5'h04, 32'hFF01_FF15);
        chk("R4 req", {in_req, in_we, in_addr}, {1'b1, 1'b0, 8'h15});
        hread(5'h04, v); chk("R3 R4 cmd busy view", v, 32'h8101_0015);
        @(negedge clk);
        chk("R7 req held", {in_req, in_addr}, {1'b1, 8'h15});
        ack_with(8'hC3);
        hread(5'h04, v); chk("R5 busy clear", v, 32'h0101_0015);
        hread(5'h08, v); chk("R5 ldata", v, 32'h0000_00C3);
        chk("R7 req dropped", {31'd0, in_req}, 0);
    endtask

    task automatic t_write;
        logic [31:0] v;
        hwrite(5'h04, 32'h0001_0022);
        chk("R6 armed no req", {31'd0, in_req}, 0);
        hread(5'h04, v); chk("R3 cmd write view", v, 32'h0001_0022);
        hwrite(5'h08, 32'hDEAD_BE5A);
        chk("R6 write req", {in_req, in_we, in_addr, in_wdata}, {1'b1, 1'b1, 8'h22, 8'h5A});
        @(negedge clk); @(negedge clk);
        chk("R7 write held", {in_req, in_we, in_addr, in_wdata}, {1'b1, 1'b1, 8'h22, 8'h5A});
        ack_with(8'h00);
        chk("R7 write done", {31'd0, in_req}, 0);
        hread(5'h08, v); chk("R6 ldata kept", v, 32'hDEAD_BE5A);
    endtask

    task automatic t_busy_ignore;
        logic [31:0] v;
        hwrite(5'h04, 32'h0100_0015);
        hwrite(5'h04, 32'h0000_0033);
        hwrite(5'h08, 32'h0000_00AB);
        hread(5'h04, v); chk("R8 cmd locked", v, 32'h8100_0015);
        chk("R8 still read", {in_req, in_we, in_addr}, {1'b1, 1'b0, 8'h15});
        ack_with(8'h42);
        hread(5'h08, v); chk("R8 ldata from read", v, 32'h0000_0042);
        @(negedge clk);
        chk("R8 no extra req", {31'd0, in_req}, 0);
    endtask

    task automatic t_ldata_only;
        logic [31:0] v;
        hwrite(5'h08, 32'h0000_0077);
        chk("R12 no req", {31'd0, in_req}, 0);
        hread(5'h08, v); chk("R12 stored", v, 32'h0000_0077);
    endtask

    task automatic t_udata;
        logic [31:0] v;
        hwrite(5'h0C, 32'hA5A5_0F0F);
        chk("R11 no req", {31'd0, in_req}, 0);
        hread(5'h0C, v); chk("R11 udata", v, 32'hA5A5_0F0F);
    endtask

    task automatic t_flags;
        logic [31:0] v;
        hread(5'h14, v); chk("R9 done flag", v, 32'h1);
        hwrite(5'h14, 32'h1);
        hread(5'h14, v); chk("R9 w1c", v, 32'h0);
        @(negedge clk); sub_irq = 1'b1;
        @(negedge clk); sub_irq = 1'b0;
        hread(5'h14, v); chk("R9 sub set", v, 32'h2);
        @(negedge clk); sub_irq = 1'b1;
        hwrite(5'h14, 32'h2);
        hread(5'h14, v); chk("R9 set wins", v, 32'h2);
        sub_irq = 1'b0;
    endtask

    task automatic t_irq;
        chk("R10 no enable", {31'd0, irq_o}, 0);
        hwrite(5'h10, 32'h1);
        chk("R10 other bit", {31'd0, irq_o}, 0);
        hwrite(5'h10, 32'h2);
        chk("R10 sub enabled", {31'd0, irq_o}, 1);
        hwrite(5'h14, 32'h2);
        chk("R10 cleared", {31'd0, irq_o}, 0);
        hwrite(5'h10, 32'h1);
        hwrite(5'h04, 32'h0100_0001);
        ack_with(8'h10);
        chk("R10 done irq", {31'd0, irq_o}, 1);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_id();
        t_read();
        t_write();
        t_busy_ignore();
        t_ldata_only();
        t_udata();
        t_flags();
        t_irq();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule